// File: doc/BRIEF.md
# Delay-Line Phase Programming Sequencer

This block is the register-side controller of a programmable delay line used to pick the sampling point for read data. It owns the control bits of the delay line (reset, power-down, enable, clock-output enable, clock-data-recovery enable, external-select enable, a 4-bit output-phase select, a 3-bit frequency code and a clock power-save bit), and it watches two status inputs from the analog line: lock and clock-output-enable readback.

Software or a tuning engine issues one of two commands through a start strobe. The initialise command steps the line through reset and power-down, loads a frequency code derived from the supplied clock rate, enables the line and waits for lock. The set-phase command moves the line to a new output phase using a handshake that keeps the output clock disabled while the select changes. Each status wait is bounded: the status is sampled once on entry and then once per microsecond, at most a fixed number of times, and the command ends with a done pulse on success or a timeout pulse on failure.

Top module: `dly_phase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timeout` and `reject` are 0, `dll_pwrsave` is 1 and every other delay-line control output (including `dll_sel` and `dll_freq`) is 0.
- R2: An initialise command (`cmd_op`=0) changes the controls one step per clock, starting the clock after acceptance: power-save off; reset on; power-down on; frequency code loaded; reset off; power-down off; line enable on; clock-output enable on; then the lock wait begins.
- R3: The frequency code is the number of the bounds 112, 125, 137, 150, 162, 175 and 187 MHz that `cmd_rate_mhz` exceeds, when the rate is at most 200 MHz; a rate above 200 MHz gives code 0. The code changes only while reset and power-down are both on.
- R4: The lock wait samples `st_lock` on its first cycle and then every CLK_MHZ cycles; when a sample reads 1 the command ends with `done`, and when MAX_POLLS samples (default 50) have all read 0 it ends with `timeout`.
- R5: A set-phase command (`cmd_op`=1) first clears the recovery enable and clock-output enable while setting external select and line enable (one clock); waits for `st_ck_out` to read 0; writes the select (one clock); sets clock-output enable (one clock); waits for `st_ck_out` to read 1; finally sets the recovery enable and clears external select in the same clock as `done`. Recovery enable and external select are never both 1.
- R6: The value written to `dll_sel` for phase index p (0..15) is the reflected binary Gray code of p, i.e. 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8 in index order.
- R7: Each of the two set-phase status waits follows the sampling and limit rule of R4 and ends the command with `timeout` when exhausted, leaving the controls as they were.
- R8: `busy` rises the clock after an accepted start and falls in the same clock that the one-cycle `done` or `timeout` pulse is high; at most one of `done`, `timeout`, `reject` is high in any clock.
- R9: A start strobe while `busy` is high is ignored, including its opcode and phase.
- R10: A set-phase command with `cmd_phase` above 15 produces a one-cycle `reject` pulse in the following clock, `busy` stays 0 and no control output changes.
- R11: `dll_sel` only changes while the clock-output enable is 0 and was 0 in the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_MHZ MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Command strobe, sampled while idle |
| cmd_op | input | 1 | 0 = initialise, 1 = set phase |
| cmd_phase | input | 5 | Requested phase index, valid 0..15 |
| cmd_rate_mhz | input | 9 | Line clock rate in MHz for the frequency code |
| st_lock | input | 1 | Delay-line lock status |
| st_ck_out | input | 1 | Clock-output-enable readback status |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle success pulse |
| timeout | output | 1 | One-cycle status-wait failure pulse |
| reject | output | 1 | One-cycle pulse for an out-of-range phase |
| dll_pwrsave | output | 1 | Clock power-save enable |
| dll_rst | output | 1 | Delay-line reset |
| dll_pdn | output | 1 | Delay-line power-down |
| dll_en | output | 1 | Delay-line enable |
| dll_ck_out_en | output | 1 | Clock-output enable |
| dll_cdr_en | output | 1 | Clock-data-recovery enable |
| dll_cdr_ext | output | 1 | External phase select enable |
| dll_sel | output | 4 | Gray-coded output phase select |
| dll_freq | output | 3 | Frequency range code |

## Verification
A sequencer that has strayed into the wrong step shows at the control outputs within one clock, because every step changes a distinct bit in a fixed order, so a per-clock comparison against an independent model pins the first wrong edge. A wrong poll counter or tick divider appears as a `done` or `timeout` pulse shifted by whole microseconds, or as a wait that ends after the wrong number of samples; the stuck-status runs measure that limit exactly. A wrong captured phase or frequency code appears as a wrong `dll_sel` or `dll_freq` value in the single clock where that field is written.

// File: rtl/dly_seq_pkg.sv
// Shared types for the delay-line phase sequencer.
// Assumes: 16 output phases (4-bit select) and 8 frequency ranges (3-bit code).
package dly_seq_pkg;

    localparam int SEL_W  = 4;
    localparam int FREQ_W = 3;

    localparam logic OP_INIT  = 1'b0;
    localparam logic OP_PHASE = 1'b1;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_I_PSAVE,
        ST_I_RST,
        ST_I_PDN,
        ST_I_FREQ,
        ST_I_UNRST,
        ST_I_UNPDN,
        ST_I_EN,
        ST_I_CKO,
        ST_I_LOCK,
        ST_P_QUIESCE,
        ST_P_WLOW,
        ST_P_SEL,
        ST_P_CKO,
        ST_P_WHIGH,
        ST_P_FIN
    } seq_state_e;

    typedef struct packed {
        logic              pwrsave;
        logic              rst;
        logic              pdn;
        logic              en;
        logic              ck_out;
        logic              cdr_en;
        logic              cdr_ext;
        logic [SEL_W-1:0]  sel;
        logic [FREQ_W-1:0] freq;
    } dll_ctl_t;

    localparam dll_ctl_t CTL_RESET = '{pwrsave: 1'b1, default: '0};

    // Reflected binary Gray code of a phase index.
    function automatic logic [SEL_W-1:0] to_gray(input logic [SEL_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/dly_us_tick.sv
// Microsecond tick divider.
// Produces a tick every DIV clocks; a restart makes the next clock a tick,
// so a status wait samples on its first cycle and then once per microsecond.
module dly_us_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Down-counter that reloads after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= CW'(DIV - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/dly_freq_code.sv
// Clock-rate to frequency-code map.
// Code = number of range bounds below the rate; above the last bound the
// code falls back to 0. Purely combinational.
module dly_freq_code #(
    parameter int          RATE_W = 9,
    parameter int          NB     = 8,
    parameter int unsigned BOUNDS [NB] = '{112, 125, 137, 150, 162, 175, 187, 200}
) (
    input  logic [RATE_W-1:0]      rate_mhz,
    output logic [$clog2(NB)-1:0]  code
);
    localparam int CODE_W = $clog2(NB);
    localparam int PADW   = 32 - RATE_W;

    logic [NB-1:0] above;

    for (genvar g = 0; g < NB; g++) begin : g_cmp
        assign above[g] = ({{PADW{1'b0}}, rate_mhz} > BOUNDS[g]);
    end

    // Count exceeded bounds; out-of-table rates map to code 0.
    always_comb begin
        logic [CODE_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NB - 1; i++) begin
            acc = acc + CODE_W'(above[i]);
        end
        code = above[NB-1] ? '0 : acc;
    end

endmodule

// File: rtl/dly_poll_unit.sv
// Bounded status poll.
// On each tick while active, a hit gives pass; a miss on the last allowed
// sample gives expire. Restart clears the sample count.
module dly_poll_unit #(
    parameter int MAX_POLLS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    input  logic tick,
    input  logic hit,
    output logic pass,
    output logic expire
);
    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [PW-1:0] cnt;
    logic          sample;

    assign sample = active && tick;
    assign pass   = sample && hit;
    assign expire = sample && !hit && (cnt == PW'(MAX_POLLS - 1));

    // Count failed samples of the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (sample && !hit && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dly_phase_seq.sv
// Delay-line phase programming sequencer (top).
// Runs the initialise and set-phase command sequences on the delay-line
// control bits, one control step per clock, with bounded status waits.
// Assumes: status inputs are synchronous to clk; CLK_MHZ is an integer.
module dly_phase_seq
    import dly_seq_pkg::*;
#(
    parameter int CLK_MHZ   = 50,
    parameter int MAX_POLLS = 50,
    parameter int PHASE_W   = 5,
    parameter int RATE_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cmd_op,
    input  logic [PHASE_W-1:0]  cmd_phase,
    input  logic [RATE_W-1:0]   cmd_rate_mhz,
    input  logic                st_lock,
    input  logic                st_ck_out,
    output logic                busy,
    output logic                done,
    output logic                timeout,
    output logic                reject,
    output logic                dll_pwrsave,
    output logic                dll_rst,
    output logic                dll_pdn,
    output logic                dll_en,
    output logic                dll_ck_out_en,
    output logic                dll_cdr_en,
    output logic                dll_cdr_ext,
    output logic [SEL_W-1:0]    dll_sel,
    output logic [FREQ_W-1:0]   dll_freq
);
    localparam int                 NUM_PHASES = 1 << SEL_W;
    localparam logic [PHASE_W-1:0] PH_LIMIT   = PHASE_W'(NUM_PHASES);

    seq_state_e          state;
    dll_ctl_t            ctl;
    logic [SEL_W-1:0]    sel_q;
    logic [FREQ_W-1:0]   code_q;
    logic [FREQ_W-1:0]   fcode;
    logic                restart;
    logic                poll_active;
    logic                poll_hit;
    logic                tick;
    logic                pass;
    logic                expire;

    dly_freq_code #(
        .RATE_W (RATE_W),
        .NB     (1 << FREQ_W)
    ) u_fcode (
        .rate_mhz (cmd_rate_mhz),
        .code     (fcode)
    );

    dly_us_tick #(
        .DIV (CLK_MHZ)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    dly_poll_unit #(
        .MAX_POLLS (MAX_POLLS)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .active  (poll_active),
        .tick    (tick),
        .hit     (poll_hit),
        .pass    (pass),
        .expire  (expire)
    );

    // Restart the tick and sample count in the step just before each wait.
    assign restart = (state == ST_I_CKO) || (state == ST_P_QUIESCE) || (state == ST_P_CKO);

    // Select which status condition the current wait is looking for.
    always_comb begin
        poll_active = 1'b1;
        poll_hit    = 1'b0;
        case (state)
            ST_I_LOCK:  poll_hit = st_lock;
            ST_P_WLOW:  poll_hit = !st_ck_out;
            ST_P_WHIGH: poll_hit = st_ck_out;
            default:    poll_active = 1'b0;
        endcase
    end

    // Command acceptance, step sequencing and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ctl     <= CTL_RESET;
            sel_q   <= '0;
            code_q  <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
            reject  <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            reject  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        if (cmd_op == OP_INIT) begin
                            code_q <= fcode;
                            state  <= ST_I_PSAVE;
                        end else if (cmd_phase < PH_LIMIT) begin
                            sel_q <= to_gray(cmd_phase[SEL_W-1:0]);
                            state <= ST_P_QUIESCE;
                        end else begin
                            reject <= 1'b1;
                        end
                    end
                end
                ST_I_PSAVE: begin
                    ctl.pwrsave <= 1'b0;
                    state       <= ST_I_RST;
                end
                ST_I_RST: begin
                    ctl.rst <= 1'b1;
                    state   <= ST_I_PDN;
                end
                ST_I_PDN: begin
                    ctl.pdn <= 1'b1;
                    state   <= ST_I_FREQ;
                end
                ST_I_FREQ: begin
                    ctl.freq <= code_q;
                    state    <= ST_I_UNRST;
                end
                ST_I_UNRST: begin
                    ctl.rst <= 1'b0;
                    state   <= ST_I_UNPDN;
                end
                ST_I_UNPDN: begin
                    ctl.pdn <= 1'b0;
                    state   <= ST_I_EN;
                end
                ST_I_EN: begin
                    ctl.en <= 1'b1;
                    state  <= ST_I_CKO;
                end
                ST_I_CKO: begin
                    ctl.ck_out <= 1'b1;
                    state      <= ST_I_LOCK;
                end
                ST_I_LOCK: begin
                    if (pass) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (expire) begin
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_P_QUIESCE: begin
                    ctl.cdr_en  <= 1'b0;
                    ctl.ck_out  <= 1'b0;
                    ctl.cdr_ext <= 1'b1;
                    ctl.en      <= 1'b1;
                    state       <= ST_P_WLOW;
                end
                ST_P_WLOW: begin
                    if (pass) begin
                        state <= ST_P_SEL;
                    end else if (expire) begin
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_P_SEL: begin
                    ctl.sel <= sel_q;
                    state   <= ST_P_CKO;
                end
                ST_P_CKO: begin
                    ctl.ck_out <= 1'b1;
                    state      <= ST_P_WHIGH;
                end
                ST_P_WHIGH: begin
                    if (pass) begin
                        state <= ST_P_FIN;
                    end else if (expire) begin
                        timeout <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_P_FIN: begin
                    ctl.cdr_en  <= 1'b1;
                    ctl.cdr_ext <= 1'b0;
                    done        <= 1'b1;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign dll_pwrsave   = ctl.pwrsave;
    assign dll_rst       = ctl.rst;
    assign dll_pdn       = ctl.pdn;
    assign dll_en        = ctl.en;
    assign dll_ck_out_en = ctl.ck_out;
    assign dll_cdr_en    = ctl.cdr_en;
    assign dll_cdr_ext   = ctl.cdr_ext;
    assign dll_sel       = ctl.sel;
    assign dll_freq      = ctl.freq;

endmodule

// File: rtl/dly_phase_seq_chk.sv
// Property checker for the delay-line sequencer, bound to every instance.
// Assumes the top's port names; checks port relations over time only.
module dly_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       reject,
    input logic       dll_rst,
    input logic       dll_pdn,
    input logic       dll_ck_out_en,
    input logic       dll_cdr_en,
    input logic       dll_cdr_ext,
    input logic [3:0] dll_sel,
    input logic [2:0] dll_freq
);
    p_result_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, timeout, reject}));

    p_result_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |-> !busy);

    p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start));

    p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (!busy && $stable(dll_sel) && $stable(dll_freq)));

    p_sel_glitchfree_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dll_sel) |-> (!dll_ck_out_en && !$past(dll_ck_out_en)));

    p_cdr_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dll_cdr_en && dll_cdr_ext));

    p_ckout_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_ck_out_en) |-> !dll_cdr_en);

    p_freq_in_pdn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dll_freq) |-> (dll_pdn && dll_rst));

endmodule

bind dly_phase_seq dly_phase_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start     (cmd_start),
    .busy          (busy),
    .done          (done),
    .timeout       (timeout),
    .reject        (reject),
    .dll_rst       (dll_rst),
    .dll_pdn       (dll_pdn),
    .dll_ck_out_en (dll_ck_out_en),
    .dll_cdr_en    (dll_cdr_en),
    .dll_cdr_ext   (dll_cdr_ext),
    .dll_sel       (dll_sel),
    .dll_freq      (dll_freq)
);

// File: tb/tb_dly_phase_seq.sv
// Bench for the delay-line sequencer: behavioural model stepped by tasks,
// compared with every output on every falling clock edge.
module tb_dly_phase_seq;
    localparam int CLK_MHZ   = 50;
    localparam int MAX_POLLS = 50;
    localparam int PHASE_W   = 5;
    localparam int RATE_W    = 9;
    localparam int GRAY [16] = '{0, 1, 3, 2, 6, 7, 5, 4, 12, 13, 15, 14, 10, 11, 9, 8};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n, cmd_start, cmd_op;
    logic [PHASE_W-1:0] cmd_phase;
    logic [RATE_W-1:0]  cmd_rate_mhz;
    logic               st_lock, st_ck_out;
    logic               busy, done, timeout, reject;
    logic               dll_pwrsave, dll_rst, dll_pdn, dll_en, dll_ck_out_en, dll_cdr_en, dll_cdr_ext;
    logic [3:0]         dll_sel;
    logic [2:0]         dll_freq;

    dly_phase_seq #(
        .CLK_MHZ (CLK_MHZ), .MAX_POLLS (MAX_POLLS), .PHASE_W (PHASE_W), .RATE_W (RATE_W)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_op (cmd_op),
        .cmd_phase (cmd_phase), .cmd_rate_mhz (cmd_rate_mhz),
        .st_lock (st_lock), .st_ck_out (st_ck_out),
        .busy (busy), .done (done), .timeout (timeout), .reject (reject),
        .dll_pwrsave (dll_pwrsave), .dll_rst (dll_rst), .dll_pdn (dll_pdn), .dll_en (dll_en),
        .dll_ck_out_en (dll_ck_out_en), .dll_cdr_en (dll_cdr_en), .dll_cdr_ext (dll_cdr_ext),
        .dll_sel (dll_sel), .dll_freq (dll_freq)
    );

    // Delay-line status responder.
    int cko_dly = 3, lock_dly = 5, cko_cnt, lock_cnt;
    bit cko_stuck = 0, lock_stuck = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            st_ck_out <= 1'b0; cko_cnt <= 0; st_lock <= 1'b0; lock_cnt <= 0;
        end else begin
            if (dll_ck_out_en != st_ck_out && !cko_stuck) begin
                if (cko_cnt + 1 >= cko_dly) begin st_ck_out <= dll_ck_out_en; cko_cnt <= 0; end
                else cko_cnt <= cko_cnt + 1;
            end else cko_cnt <= 0;
            if (dll_en && dll_ck_out_en && !dll_rst && !dll_pdn && !lock_stuck) begin
                if (lock_cnt >= lock_dly) st_lock <= 1'b1;
                else lock_cnt <= lock_cnt + 1;
            end else begin lock_cnt <= 0; st_lock <= 1'b0; end
        end
    end

    // Model state.
    int    checks = 0, errors = 0;
    bit    cmp_on = 0;
    int    e_busy, e_done, e_to, e_rej, e_psave, e_rst, e_pdn, e_en, e_cko, e_cdr, e_ext, e_sel, e_freq;
    string tag_cfg = "R1", tag_res = "R8";

    task automatic chk(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R8", "busy", busy, e_busy);
            chk("R8", "done", done, e_done);
            chk(tag_res, "timeout", timeout, e_to);
            chk("R10", "reject", reject, e_rej);
            chk(tag_cfg, "pwrsave", dll_pwrsave, e_psave);
            chk(tag_cfg, "rst", dll_rst, e_rst);
            chk(tag_cfg, "pdn", dll_pdn, e_pdn);
            chk(tag_cfg, "en", dll_en, e_en);
            chk(tag_cfg, "ck_out_en", dll_ck_out_en, e_cko);
            chk(tag_cfg, "cdr_en", dll_cdr_en, e_cdr);
            chk(tag_cfg, "cdr_ext", dll_cdr_ext, e_ext);
            chk(tag_cfg, "sel", dll_sel, e_sel);
            chk(tag_cfg, "freq", dll_freq, e_freq);
        end
    end

    function automatic int fcode(int m);
        if (m <= 112) return 0;
        else if (m <= 125) return 1;
        else if (m <= 137) return 2;
        else if (m <= 150) return 3;
        else if (m <= 162) return 4;
        else if (m <= 175) return 5;
        else if (m <= 187) return 6;
        else if (m <= 200) return 7;
        return 0;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        e_done = 0; e_to = 0; e_rej = 0;
    endtask

    // kind 0: ck_out readback low, 1: readback high, 2: lock.
    task automatic poll(int kind, output bit ok);
        for (int k = 0; k < MAX_POLLS; k++) begin
            bit hit;
            hit = (kind == 0) ? !st_ck_out : (kind == 1) ? st_ck_out : st_lock;
            if (hit) begin tick(); ok = 1; return; end
            if (k == MAX_POLLS - 1) begin tick(); e_busy = 0; e_to = 1; ok = 0; return; end
            repeat (CLK_MHZ) tick();
        end
        ok = 0;
    endtask

    task automatic do_init(int mhz, bit expect_ok);
        bit ok;
        tag_cfg = "R2"; tag_res = "R4";
        cmd_op = 1'b0; cmd_rate_mhz = RATE_W'(mhz); cmd_start = 1'b1;
        tick(); cmd_start = 1'b0; e_busy = 1;
        tick(); e_psave = 0;
        tick(); e_rst = 1;
        tick(); e_pdn = 1;
        tick(); e_freq = fcode(mhz);
        tick(); e_rst = 0;
        tick(); e_pdn = 0;
        tick(); e_en = 1;
        tick(); e_cko = 1;
        poll(2, ok);
        if (ok) begin e_busy = 0; e_done = 1; end
        chk("R4", "init ends in done", ok, expect_ok);
        tick();
        chk("R3", "frequency code", dll_freq, fcode(mhz));
    endtask

    task automatic do_phase(int ph, bit poke, bit expect_ok);
        bit ok;
        tag_cfg = "R5"; tag_res = "R7";
        cmd_op = 1'b1; cmd_phase = PHASE_W'(ph); cmd_start = 1'b1;
        tick();
        if (ph > 15) begin
            cmd_start = 1'b0; e_rej = 1;
            chk("R10", "busy after bad phase", busy, 0);
            tick();
            chk("R10", "select kept", dll_sel, e_sel);
            return;
        end
        e_busy = 1;
        if (poke) begin cmd_op = 1'b0; cmd_phase = 5'd9; end  // R9: held start while busy
        else cmd_start = 1'b0;
        tick(); cmd_start = 1'b0;
        e_cdr = 0; e_cko = 0; e_ext = 1; e_en = 1;
        poll(0, ok);
        if (ok) begin
            tick(); e_sel = GRAY[ph];
            tick(); e_cko = 1;
            poll(1, ok);
            if (ok) begin
                tick(); e_cdr = 1; e_ext = 0; e_busy = 0; e_done = 1;
            end
        end
        chk("R7", "set-phase ends in done", ok, expect_ok);
        tick();
        if (ok) begin
            chk("R6", "gray select", dll_sel, GRAY[ph]);
            if (poke) chk("R9", "second start ignored", dll_sel, GRAY[ph]);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_start = 1'b0; cmd_op = 1'b0; cmd_phase = '0; cmd_rate_mhz = '0;
        e_busy = 0; e_done = 0; e_to = 0; e_rej = 0; e_psave = 1; e_rst = 0; e_pdn = 0;
        e_en = 0; e_cko = 0; e_cdr = 0; e_ext = 0; e_sel = 0; e_freq = 0;
        @(posedge clk); #1; cmp_on = 1;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "pwrsave after reset", dll_pwrsave, 1);
        chk("R1", "sel after reset", dll_sel, 0);
        tick();
        // R2/R3/R4: initialise at several rates
        do_init(100, 1);
        do_init(113, 1);
        do_init(126, 1);
        do_init(150, 1);
        do_init(163, 1);
        do_init(200, 1);
        do_init(201, 1);
        // R5/R6: every phase
        for (int p = 0; p < 16; p++) do_phase(p, 0, 1);
        // R7: slow readback needs several samples
        cko_dly = 120;
        do_phase(6, 0, 1);
        cko_dly = 3;
        // R9: start held while busy
        do_phase(11, 1, 1);
        // R10: out-of-range phases
        do_phase(16, 0, 0);
        do_phase(31, 0, 0);
        // R7: readback never drops -> timeout
        cko_stuck = 1;
        do_phase(3, 0, 0);
        cko_stuck = 0;
        repeat (10) tick();
        do_phase(3, 0, 1);
        // R4: no lock -> timeout, then recovery
        lock_stuck = 1;
        do_init(120, 0);
        lock_stuck = 0;
        do_init(120, 1);
        repeat (3) tick();
        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule